// File: doc/BRIEF.md
# Double-Buffered Serial Frame Loader

This block takes a stream of colour bytes from a slow byte source, such as the receive side of a serial link, and assembles them into 24-bit pixel words for a 64 by 32 colour matrix. It stores the words in a dual-port memory that holds two complete images. New pixels always go into the half that is not being shown, while the scan driver reads the shown half through its own port at full rate. The two ports never wait for each other.

When a complete image has been written, the block raises a pending flag and stops taking bytes. The scan driver signals the end of each refresh pass. At the next such pulse the two halves change roles, so the display never shows a partly loaded image. The byte phase and pixel position can be brought back into line in two ways: a start-of-frame marker that comes with a byte, or a pause in the stream longer than a set limit. Either one stops a single lost byte from shifting every later colour.

Top module: `frame_loader`

## Requirements
- R1: A synchronous reset sets the shown-buffer select `disp_sel` to 0 and clears `swap_pending`. The byte phase and pixel position return to the first byte of pixel 0.
- R2: Each group of three accepted bytes, taken in the order red, green, blue, is written as one word {red[23:16], green[15:8], blue[7:0]}. The word goes to pixel index row*64+col of the back half, the half whose memory address MSB is the inverse of `disp_sel`. Pixels arrive row by row, with columns 0 to 63 inside each row.
- R3: `swap_pending` goes high in the cycle after the 2048th pixel word is written, and not before. Bytes that arrive while it is high are ignored and do not count toward the next image.
- R4: `disp_sel` inverts, and `swap_pending` clears, one cycle after a `frame_done` pulse seen while `swap_pending` is high. A `frame_done` pulse while nothing is pending changes nothing.
- R5: `rd_data` returns the word at pixel `rd_addr` of the shown half, registered, one cycle after the address is applied.
- R6: A byte that comes with `in_sof` high is taken as the red byte of pixel 0, whatever the earlier phase and position were.
- R7: After `IDLE_LIM` consecutive cycles with no valid byte, the next byte is taken as the red byte of pixel 0.
- R8: Writes to the back half never change what the read port returns from the shown half, including while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_data | input | 8 | Colour byte |
| in_sof | input | 1 | Marks this byte as the first byte of an image |
| frame_done | input | 1 | One-cycle pulse from the scan driver at the end of a refresh pass |
| rd_addr | input | 11 | Pixel index read by the scan driver |
| rd_data | output | 24 | Pixel word from the shown half, one cycle after the address |
| disp_sel | output | 1 | Which memory half is shown |
| swap_pending | output | 1 | A full image waits in the back half |

## Verification
The main test loads complete images of random pixel words with random gaps between bytes. Images are sent both with and without a start-of-frame marker. Each shown image is then read back in full. Extra bytes sent while a swap is pending check that the next image still needs exactly 2048 pixels. Stray bytes placed before a marked image, and a partial pixel followed by a long pause, check that each realignment path recovers on its own. Occasional reads of the shown half during loading show whether any write reaches the wrong half.

// File: rtl/frame_loader.sv
module frame_loader #(
  parameter int COLS     = 64,
  parameter int ROWS     = 32,
  parameter int CW       = 8,
  parameter int IDLE_LIM = 256
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               in_valid,
  input  logic [CW-1:0]                      in_data,
  input  logic                               in_sof,
  input  logic                               frame_done,
  input  logic [$clog2(COLS*ROWS)-1:0]       rd_addr,
  output logic [3*CW-1:0]                    rd_data,
  output logic                               disp_sel,
  output logic                               swap_pending
);
  localparam int NPIX = COLS * ROWS;
  localparam int PW   = $clog2(NPIX);
  localparam int AW   = PW + 1;
  localparam int DW   = 3 * CW;
  localparam int IW   = $clog2(IDLE_LIM + 1);

  logic [1:0]    phase;
  logic [CW-1:0] red_q, grn_q;
  logic [PW-1:0] ptr;
  logic [IW-1:0] idle;
  logic [DW-1:0] mem [2*NPIX];

  wire          take     = in_valid && !swap_pending;
  wire          last_pix = ptr == PW'(NPIX - 1);
  wire          wr_en    = take && !in_sof && phase == 2'd2;
  wire [AW-1:0] wr_addr  = {~disp_sel, ptr};
  wire          timeout  = !in_valid && idle == IW'(IDLE_LIM - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= 2'd0;
      ptr          <= '0;
      idle         <= '0;
      disp_sel     <= 1'b0;
      swap_pending <= 1'b0;
    end else begin
      idle <= (in_valid || timeout) ? '0 : idle + 1'b1;
      if (take) begin
        if (in_sof) begin
          red_q <= in_data;
          phase <= 2'd1;
          ptr   <= '0;
        end else begin
          case (phase)
            2'd0: begin red_q <= in_data; phase <= 2'd1; end
            2'd1: begin grn_q <= in_data; phase <= 2'd2; end
            default: begin
              phase <= 2'd0;
              ptr   <= last_pix ? '0 : ptr + 1'b1;
              if (last_pix) swap_pending <= 1'b1;
            end
          endcase
        end
      end else if (timeout) begin
        phase <= 2'd0;
        ptr   <= '0;
      end
      if (frame_done && swap_pending) begin
        disp_sel     <= ~disp_sel;
        swap_pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {red_q, grn_q, in_data};
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[{disp_sel, rd_addr}];
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!disp_sel && !swap_pending && ptr == '0 && phase == 2'd0)); // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3); // R2
  AST_NO_WRITE_PENDING: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !swap_pending); // R3
  AST_PENDING_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[PW-1:0] == PW'(NPIX - 1)) |=> swap_pending); // R3
  AST_SWAP_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_sel) |-> $past(swap_pending && frame_done)); // R4
  AST_SOF_REALIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && !swap_pending) |=> (phase == 2'd1 && ptr == '0)); // R6
  AST_WRITE_BACK_HALF: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr[AW-1] != disp_sel)); // R8
endmodule

// File: tb/frame_loader_bench.sv
`timescale 1ns/1ps
module frame_loader_bench;
  localparam int COLS = 64, ROWS = 32, NPIX = COLS * ROWS, IDLE = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, frame_done = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [10:0] rd_addr = '0;
  logic [23:0] rd_data;
  logic        disp_sel, swap_pending;

  always #2.5 clk = ~clk;

  frame_loader #(.COLS(COLS), .ROWS(ROWS), .CW(8), .IDLE_LIM(IDLE)) u_frame_loader (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .frame_done(frame_done), .rd_addr(rd_addr), .rd_data(rd_data),
    .disp_sel(disp_sel), .swap_pending(swap_pending));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [23:0] model [0:2*NPIX-1];
  bit model_sel = 0;

  function automatic int pix_index(int row, int col);
    return row * COLS + col;
  endfunction

  function automatic logic [23:0] pix_word(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    return {r, g, b};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit sof);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sof = sof;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    repeat ($urandom_range(0, 1)) @(negedge clk);
  endtask

  task automatic read_one(int a, string req);
    @(negedge clk);
    rd_addr = 11'(a);
    @(negedge clk);
    chk(rd_data === model[{model_sel, 11'(a)}], req, rd_data, model[{model_sel, 11'(a)}]);
  endtask

  task automatic send_frame(bit first_sof);
    for (int row = 0; row < ROWS; row++) begin
      for (int col = 0; col < COLS; col++) begin
        logic [7:0] r, g, b;
        int p;
        r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
        p = pix_index(row, col);
        model[{~model_sel, 11'(p)}] = pix_word(r, g, b);
        send_byte(r, first_sof && p == 0);
        send_byte(g, 0);
        send_byte(b, 0);
        if (p == NPIX - 2) chk(swap_pending == 1'b0, "R3 early pending", swap_pending, 0);
        if (p % 256 == 100 && p < NPIX - 1) read_one($urandom_range(0, NPIX - 1), "R8 live read");
      end
    end
    chk(swap_pending == 1'b1, "R3 pending after last", swap_pending, 1);
  endtask

  task automatic pulse_done();
    bit was_pending;
    was_pending = swap_pending;
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    if (was_pending) model_sel = ~model_sel;
    chk(disp_sel == model_sel, "R4 select", disp_sel, model_sel);
    chk(swap_pending == 1'b0, "R4 pending clear", swap_pending, 0);
  endtask

  task automatic read_front(string req);
    int miss = 0, first = -1;
    for (int a = 0; a < NPIX; a++) begin
      @(negedge clk);
      rd_addr = 11'(a);
      @(negedge clk);
      if (rd_data !== model[{model_sel, 11'(a)}]) begin
        miss++;
        if (first < 0) first = a;
      end
    end
    if (first < 0) chk(1, req, 0, 0);
    else chk(0, req, rd_data, model[{model_sel, 11'(first)}]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(disp_sel == 1'b0, "R1 disp_sel", disp_sel, 0);
    chk(swap_pending == 1'b0, "R1 pending", swap_pending, 0);

    pulse_done();

    send_frame(1);
    for (int i = 0; i < 10; i++) send_byte(8'($urandom), i == 3);
    chk(swap_pending == 1'b1, "R3 ignored bytes keep pending", swap_pending, 1);
    pulse_done();
    read_front("R2 R5 frame A");

    send_frame(0);
    read_front("R8 front intact while pending");
    pulse_done();
    read_front("R2 frame B");

    send_byte(8'h5a, 0);
    send_byte(8'ha5, 0);
    send_frame(1);
    pulse_done();
    read_front("R6 sof realign");

    for (int i = 0; i < 16; i++) send_byte(8'($urandom), 0);
    repeat (IDLE + 10) @(negedge clk);
    send_frame(0);
    pulse_done();
    read_front("R7 idle realign");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule